// File: doc/BRIEF.md
# Clock Lane High-Speed Burst Sequencer

This block steers the clock lane of a serial PHY transmitter into high-speed (HS) clocking and back to low-power (LP) idle. It drives a two-bit LP line state, an enable for the HS differential driver and a gate for the toggling HS clock. A start request begins the entry sequence. The block raises a clock-ready level when the data lanes may begin their own LP-to-HS transition. A stop request reports that the last data lane has finished its trail and gone back to LP. In response, the block keeps the clock running for a programmed time, then trails and exits to LP-11.

Each interval is an unsigned count of reference-clock cycles, supplied on its own input. Every count is captured when a burst is accepted, and a zero count is treated as one cycle. The block stretches the LP-00 prepare phase and the final LP-11 exit phase to at least the LP-period count. A stop request that arrives while the clock-pre count is still running is held back until the clock-ready point.

Top module: `clk_lane_hs_seq`

## Requirements
- R1: After a synchronous active-high reset, lpState is 2'b11 (bit 1 is the positive wire, bit 0 the negative wire), hsDrvEn, hsClkGate and clkReady are 0, and laneIdle is 1.
- R2: A startReq sampled while laneIdle is 1 gives LP-01 (lpState 2'b01) for eff(cfgLpx) cycles, then LP-00 (2'b00) for max(eff(cfgLpx), eff(cfgPrepare)) cycles. eff(x) is 1 when x is 0 and x otherwise.
- R3: After LP-00 the lane drives HS-0 (lpState 2'b00, hsDrvEn 1, hsClkGate 0) for eff(cfgZero) cycles. Then hsClkGate goes to 1.
- R4: clkReady stays 0 for the first eff(cfgPre) cycles of clocking. It then rises and stays 1 until a stop is taken.
- R5: A stopReq seen while clkReady is 1 drops clkReady in the next cycle. The clock keeps running for eff(cfgPost) cycles, after which the lane drives HS-0 (hsDrvEn 1, hsClkGate 0) for eff(cfgTrail) cycles.
- R6: A stopReq seen during the clock-pre count is deferred. clkReady is 1 for exactly one cycle, and then the post phase of R5 follows.
- R7: After the trail, lpState is 2'b11 with hsDrvEn 0 for max(eff(cfgLpx), eff(cfgExit)) cycles while laneIdle is still 0. laneIdle rises after that.
- R8: All timing counts are captured in the cycle a burst starts. Changes to them during the burst have no effect on that burst.
- R9: A timing count of zero behaves exactly as a count of one.
- R10: startReq while laneIdle is 0 is ignored. stopReq outside the clock-pre count and clocking-with-ready phases is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Request to enter HS clocking |
| stopReq | input | 1 | Last data lane has returned to LP |
| cfgLpx | input | 16 | LP state period count |
| cfgPrepare | input | 16 | LP-00 prepare count |
| cfgZero | input | 16 | HS-0 before clocking count |
| cfgPre | input | 16 | Clocking before data-lane entry count |
| cfgPost | input | 16 | Clocking after data-lane exit count |
| cfgTrail | input | 16 | HS-0 after last clock bit count |
| cfgExit | input | 16 | LP-11 after burst count |
| lpState | output | 2 | LP line state, bit 1 positive wire |
| hsDrvEn | output | 1 | HS differential driver enable |
| hsClkGate | output | 1 | HS clock toggling enable |
| clkReady | output | 1 | Data lanes may start HS entry |
| laneIdle | output | 1 | Lane in stop state, burst may start |

## Verification
The bench runs whole bursts over a grid of small counts. The grid includes zero counts, prepare and exit counts both below and above the LP period, and stop pulses at every cycle from the first clock-pre cycle to two cycles after the ready point. Stops inside the pre count show that a stop is deferred and not taken at once. Stops from the ready point onward show that the run length follows the stop cycle. On alternate bursts, the counts are overwritten after the start and stray start and stop pulses are driven into phases that must ignore them. This shows that the counts are captured at the start and that requests outside their window have no effect. Every cycle's outputs are compared against a phase timeline that the bench computes from the counts.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

  typedef enum logic [3:0] {
    PH_STOP, PH_LP01, PH_LP00, PH_ZERO, PH_PRE,
    PH_RUN, PH_POST, PH_TRAIL, PH_EXIT
  } phase_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LPX, SEL_PREP, SEL_ZERO,
    SEL_PRE, SEL_POST, SEL_TRAIL, SEL_EXIT
  } limSel_t;

  typedef struct packed {
    logic     capture;
    logic     clear;
    limSel_t  sel;
  } strobe_t;

  localparam int NUM_CFG   = 7;
  localparam int IDX_LPX   = 0;
  localparam int IDX_PREP  = 1;
  localparam int IDX_ZERO  = 2;
  localparam int IDX_PRE   = 3;
  localparam int IDX_POST  = 4;
  localparam int IDX_TRAIL = 5;
  localparam int IDX_EXIT  = 6;

endpackage

// File: rtl/clk_lane_timer.sv
module clk_lane_timer
  import clk_lane_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  strobe_t                         stb,
  input  logic [NUM_CFG-1:0][CNT_W-1:0]   cfgIn,
  output logic                            limitHit
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [NUM_CFG-1:0][CNT_W-1:0] capCfg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  // Counts are frozen at burst start; zero is floored to one.
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst)              capCfg[g] <= ONE;
      else if (stb.capture) capCfg[g] <= (cfgIn[g] == '0) ? ONE : cfgIn[g];
    end
  end

  always_comb begin
    case (stb.sel)
      SEL_LPX:   lim = capCfg[IDX_LPX];
      SEL_PREP:  lim = (capCfg[IDX_PREP] > capCfg[IDX_LPX]) ? capCfg[IDX_PREP] : capCfg[IDX_LPX];
      SEL_ZERO:  lim = capCfg[IDX_ZERO];
      SEL_PRE:   lim = capCfg[IDX_PRE];
      SEL_POST:  lim = capCfg[IDX_POST];
      SEL_TRAIL: lim = capCfg[IDX_TRAIL];
      SEL_EXIT:  lim = (capCfg[IDX_EXIT] > capCfg[IDX_LPX]) ? capCfg[IDX_EXIT] : capCfg[IDX_LPX];
      default:   lim = ONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || stb.clear)         cnt <= '0;
    else if (stb.sel != SEL_NONE) cnt <= cnt + ONE;
  end

  assign limitHit = (stb.sel != SEL_NONE) && (cnt == lim - ONE);

  // R2 R3 R5 R7: a timed phase never overruns its limit
  a_r9_count_in_range: assert property (@(posedge clk) disable iff (rst)
    (stb.sel != SEL_NONE) |-> (cnt < lim));

endmodule

// File: rtl/clk_lane_ctrl.sv
module clk_lane_ctrl
  import clk_lane_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     startReq,
  input  logic     stopReq,
  input  logic     limitHit,
  output strobe_t  stb,
  output logic [1:0] lpState,
  output logic     hsDrvEn,
  output logic     hsClkGate,
  output logic     clkReady,
  output logic     laneIdle
);

  phase_t state, nextState;
  logic   stopPend;

  always_comb begin
    nextState = state;
    case (state)
      PH_STOP:  if (startReq) nextState = PH_LP01;
      PH_LP01:  if (limitHit) nextState = PH_LP00;
      PH_LP00:  if (limitHit) nextState = PH_ZERO;
      PH_ZERO:  if (limitHit) nextState = PH_PRE;
      PH_PRE:   if (limitHit) nextState = PH_RUN;
      PH_RUN:   if (stopReq || stopPend) nextState = PH_POST;
      PH_POST:  if (limitHit) nextState = PH_TRAIL;
      PH_TRAIL: if (limitHit) nextState = PH_EXIT;
      PH_EXIT:  if (limitHit) nextState = PH_STOP;
      default:  nextState = PH_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PH_STOP;
    else     state <= nextState;
  end

  // Early stop is held until the ready point.
  always_ff @(posedge clk) begin
    if (rst)                           stopPend <= 1'b0;
    else if (state == PH_PRE && stopReq) stopPend <= 1'b1;
    else if (state == PH_RUN)          stopPend <= 1'b0;
  end

  always_comb begin
    stb.capture = (state == PH_STOP) && startReq;
    stb.clear   = (nextState != state);
    case (state)
      PH_LP01:  stb.sel = SEL_LPX;
      PH_LP00:  stb.sel = SEL_PREP;
      PH_ZERO:  stb.sel = SEL_ZERO;
      PH_PRE:   stb.sel = SEL_PRE;
      PH_POST:  stb.sel = SEL_POST;
      PH_TRAIL: stb.sel = SEL_TRAIL;
      PH_EXIT:  stb.sel = SEL_EXIT;
      default:  stb.sel = SEL_NONE;
    endcase
  end

  always_comb begin
    case (state)
      PH_STOP, PH_EXIT: lpState = 2'b11;
      PH_LP01:          lpState = 2'b01;
      default:          lpState = 2'b00;
    endcase
    hsDrvEn   = (state == PH_ZERO) || (state == PH_PRE) || (state == PH_RUN) ||
                (state == PH_POST) || (state == PH_TRAIL);
    hsClkGate = (state == PH_PRE) || (state == PH_RUN) || (state == PH_POST);
    clkReady  = (state == PH_RUN);
    laneIdle  = (state == PH_STOP);
  end

  a_r10_idle_holds_without_start: assert property (@(posedge clk) disable iff (rst)
    (laneIdle && !startReq) |=> laneIdle);

  a_r4_ready_after_clocking: assert property (@(posedge clk) disable iff (rst)
    $rose(clkReady) |-> $past(hsClkGate));

  a_r5_gate_falls_into_trail: assert property (@(posedge clk) disable iff (rst)
    $fell(hsClkGate) |-> (hsDrvEn && !clkReady));

  a_r7_driver_off_into_lp11: assert property (@(posedge clk) disable iff (rst)
    $fell(hsDrvEn) |-> (lpState == 2'b11));

  a_r6_deferred_stop_taken: assert property (@(posedge clk) disable iff (rst)
    (clkReady && stopPend) |=> (!clkReady && hsClkGate));

  a_r2_lp01_from_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(lpState == 2'b01) |-> $past(laneIdle));

endmodule

// File: rtl/clk_lane_hs_seq.sv
module clk_lane_hs_seq
  import clk_lane_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic             stopReq,
  input  logic [CNT_W-1:0] cfgLpx,
  input  logic [CNT_W-1:0] cfgPrepare,
  input  logic [CNT_W-1:0] cfgZero,
  input  logic [CNT_W-1:0] cfgPre,
  input  logic [CNT_W-1:0] cfgPost,
  input  logic [CNT_W-1:0] cfgTrail,
  input  logic [CNT_W-1:0] cfgExit,
  output logic [1:0]       lpState,
  output logic             hsDrvEn,
  output logic             hsClkGate,
  output logic             clkReady,
  output logic             laneIdle
);

  strobe_t stb;
  logic    limitHit;
  logic [NUM_CFG-1:0][CNT_W-1:0] cfgBus;

  always_comb begin
    cfgBus[IDX_LPX]   = cfgLpx;
    cfgBus[IDX_PREP]  = cfgPrepare;
    cfgBus[IDX_ZERO]  = cfgZero;
    cfgBus[IDX_PRE]   = cfgPre;
    cfgBus[IDX_POST]  = cfgPost;
    cfgBus[IDX_TRAIL] = cfgTrail;
    cfgBus[IDX_EXIT]  = cfgExit;
  end

  clk_lane_ctrl u_ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .stopReq(stopReq),
    .limitHit(limitHit), .stb(stb), .lpState(lpState), .hsDrvEn(hsDrvEn),
    .hsClkGate(hsClkGate), .clkReady(clkReady), .laneIdle(laneIdle)
  );

  clk_lane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .stb(stb), .cfgIn(cfgBus), .limitHit(limitHit)
  );

endmodule

// File: tb/clk_lane_hs_seq_bench.sv
module clk_lane_hs_seq_bench;

  localparam int W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, startReq, stopReq;
  logic [W-1:0] cLpx, cPrep, cZero, cPre, cPost, cTrail, cExit;
  logic [1:0] lpState;
  logic hsDrvEn, hsClkGate, clkReady, laneIdle;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int burstNo = 0;

  clk_lane_hs_seq u_clk_lane_hs_seq (
    .clk(clk), .rst(rst), .startReq(startReq), .stopReq(stopReq),
    .cfgLpx(cLpx), .cfgPrepare(cPrep), .cfgZero(cZero), .cfgPre(cPre),
    .cfgPost(cPost), .cfgTrail(cTrail), .cfgExit(cExit),
    .lpState(lpState), .hsDrvEn(hsDrvEn), .hsClkGate(hsClkGate),
    .clkReady(clkReady), .laneIdle(laneIdle)
  );

  // phase codes: 0 idle,1 lp01,2 lp00,3 hs0,4 pre,5 ready,6 post,7 trail,8 exit
  function automatic logic [5:0] expOut(int ph);
    case (ph)
      0: return {2'b11, 4'b0001};
      1: return {2'b01, 4'b0000};
      2: return {2'b00, 4'b0000};
      3: return {2'b00, 4'b1000};
      4: return {2'b00, 4'b1100};
      5: return {2'b00, 4'b1110};
      6: return {2'b00, 4'b1100};
      7: return {2'b00, 4'b1000};
      default: return {2'b11, 4'b0000};
    endcase
  endfunction

  function automatic string tagOf(int ph);
    case (ph)
      0: return "R7";
      1, 2: return "R2";
      3: return "R3";
      4, 5: return "R4";
      6, 7: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic int eff(int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic int mx(int x, int y);
    return (x > y) ? x : y;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] actOut();
    return {lpState, hsDrvEn, hsClkGate, clkReady, laneIdle};
  endfunction

  task automatic runBurst(int L, int P, int Z, int Q, int S, int T, int X,
                          int off, bit noise);
    int len[9];
    int k0, ks, total, ph, acc;
    string extra;
    len[0] = 0;
    len[1] = eff(L);
    len[2] = mx(eff(L), eff(P));
    len[3] = eff(Z);
    len[4] = eff(Q);
    len[5] = (off < 0) ? 1 : off + 1;
    len[6] = eff(S);
    len[7] = eff(T);
    len[8] = mx(eff(L), eff(X));
    k0 = len[1] + len[2] + len[3] + len[4] + 1;
    ks = k0 + off;
    total = 0;
    for (int i = 1; i < 9; i++) total += len[i];
    extra = "";
    if (off < 0) extra = {extra, " R6"};
    if (noise) extra = {extra, " R8 R10"};
    if (L == 0 || P == 0 || Z == 0 || Q == 0 || T == 0) extra = {extra, " R9"};

    @(negedge clk);
    check(actOut() == expOut(0), {"R7 idle before start", extra}, actOut(), expOut(0));
    startReq = 1'b1;
    cLpx = W'(L); cPrep = W'(P); cZero = W'(Z); cPre = W'(Q);
    cPost = W'(S); cTrail = W'(T); cExit = W'(X);
    for (int k = 1; k <= total + 1; k++) begin
      @(negedge clk);
      ph = 0; acc = 0;
      for (int p = 1; p < 9; p++) begin
        if (k > acc && k <= acc + len[p]) ph = p;
        acc += len[p];
      end
      check(actOut() == expOut(ph), {tagOf(ph), extra}, actOut(), expOut(ph));
      startReq = noise && (k < total);
      stopReq  = (k == ks) || (noise && k == 1) || (noise && off >= 0 && k == ks + 2);
      if (noise && k == 1) begin
        cLpx = '1; cPrep = '1; cZero = '1; cPre = '1;
        cPost = '1; cTrail = '1; cExit = '1;
      end
    end
    startReq = 1'b0;
    stopReq  = 1'b0;
    burstNo++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int pv[3];
    pv[0] = 0; pv[1] = 1; pv[2] = 3;
    rst = 1'b1; startReq = 1'b0; stopReq = 1'b0;
    cLpx = '0; cPrep = '0; cZero = '0; cPre = '0;
    cPost = '0; cTrail = '0; cExit = '0;
    repeat (3) @(negedge clk);
    check(actOut() == {2'b11, 4'b0001}, "R1 reset state", actOut(), {2'b11, 4'b0001});
    startReq = 1'b1;
    @(negedge clk);
    check(actOut() == {2'b11, 4'b0001}, "R1 start ignored in reset", actOut(), {2'b11, 4'b0001});
    startReq = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(actOut() == {2'b11, 4'b0001}, "R1 idle after reset", actOut(), {2'b11, 4'b0001});

    for (int iL = 0; iL < 2; iL++)
      for (int iP = 0; iP < 3; iP++)
        for (int iZ = 1; iZ < 3; iZ++)
          for (int iQ = 0; iQ < 2; iQ++)
            for (int iS = 1; iS < 3; iS++)
              for (int iT = 0; iT < 2; iT++)
                for (int iX = 0; iX < 2; iX++)
                  for (int off = -eff(iQ * 3); off <= 2; off++)
                    runBurst(iL * 2, pv[iP], iZ - (iP == 0 ? 1 : 0), iQ * 3, iS,
                             iT * 2, 1 + iX * 3, off, burstNo[0]);

    // longer counts, one burst each way
    runBurst(5, 9, 4, 8, 6, 3, 2, 4, 1'b0);
    runBurst(5, 9, 4, 8, 6, 3, 2, -8, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule